// File: doc/BRIEF.md
# External Interrupt Sense and Status

The block watches six external interrupt request pins and keeps one pending flag for each of them. Every line has its own two-bit sense select, which picks one of four modes: low level, falling edge, rising edge or both edges. Each pin passes through a two-flop synchronizer before any sensing is done. Edges are found by comparing the synchronized level with its value one cycle earlier.

Software sees the flags in an 8-bit status register. The register is read combinationally on `st_rdata`, and `st_rd` marks the cycle in which that value is consumed. A flag can be cleared by software only through a handshake: the flag is first read as 1, and a later write then puts 0 in its bit position. A flag also clears by itself when the interrupt is serviced. In low-level mode that clear happens only if the synchronized pin is high at that moment. A flag is also cleared by a transfer-engine acknowledge, unless the keep control of that line is set.

Each request output is the flag gated by a per-line enable. The register bus and all acknowledges are plain strobes with no back-pressure: a strobe takes effect at the clock edge in which it is high.

Top module: `irq_sense_status`

## Requirements
- R1: `st_rdata[5:0]` shows the flags of lines 5 to 0 (line n at bit n), and `st_rdata[7:6]` always reads 0.
- R2: Reset (`rst_n` low) and `hw_standby` high both clear every flag and every read-arm. `hw_standby` overrides any set event in the same cycle.
- R3: With sense select 2'b00 (low level), the flag sets in every cycle in which the synchronized pin is low. A pin change becomes visible on the flag three clock edges later.
- R4: With sense select 2'b01 (falling edge), the flag sets when the synchronized pin goes from 1 to 0.
- R5: With sense select 2'b10 (rising edge), the flag sets when the synchronized pin goes from 0 to 1.
- R6: With sense select 2'b11 (both edges), the flag sets on either transition of the synchronized pin.
- R7: Writing 1 to a flag bit has no effect. Writing 0 has no effect unless that flag was read as 1 since the last write.
- R8: A read strobe that returns a flag as 1 arms that line. The next write clears the arm, and if the written bit is 0 the flag also clears.
- R9: In low-level mode, `svc_ack[n]` clears flag n only if the synchronized pin is high.
- R10: In any edge mode, `svc_ack[n]` clears flag n unconditionally.
- R11: `xfer_ack[n]` clears flag n when `xfer_keep[n]` is 0, and has no effect when it is 1.
- R12: A set event wins over any clear (software, service or transfer) that lands in the same cycle.
- R13: `irq_req[n]` equals flag n AND `irq_en[n]`, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Synchronous clear of all flags and arms |
| irq_pin | input | 6 | Raw asynchronous request pins |
| sense_sel | input | 12 | Per-line sense select, line n at bits [2n+1:2n] |
| irq_en | input | 6 | Per-line request enable |
| st_rd | input | 1 | Status read strobe |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Write data, bit n targets flag n |
| st_rdata | output | 8 | Status register value |
| svc_ack | input | 6 | Per-line exception service acknowledge |
| xfer_ack | input | 6 | Per-line transfer engine acknowledge |
| xfer_keep | input | 6 | Per-line keep-flag control for transfer acknowledge |
| irq_req | output | 6 | Per-line gated request |

## Verification
Two functions can fall in the same cycle: a set event on a line and a clear of that same line. The bench provokes this by holding a low-level line low while it strobes a service acknowledge, a transfer acknowledge and an armed zero-write. It also runs a long random phase in which pins, modes and acknowledges change at once. A cycle-by-cycle reference model in the bench applies "set wins" at each edge and checks the flags and requests after every clock, so a clear that overrides a set shows up as a mismatch.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_d
);
  logic [WIDTH-1:0] meta;

  // Idle level is high, so leaving reset raises no event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= '1;
      lvl   <= '1;
      lvl_d <= '1;
    end else begin
      meta  <= raw;
      lvl   <= meta;
      lvl_d <= lvl;
    end
  end
endmodule

// File: rtl/irq_line.sv
`timescale 1ns/1ps
module irq_line
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_standby,
  input  logic       lvl,
  input  logic       lvl_d,
  input  logic [1:0] mode_i,
  input  logic       rd,
  input  logic       wr,
  input  logic       wbit,
  input  logic       svc,
  input  logic       xfer,
  input  logic       keep,
  output logic       flag
);
  sense_e mode;
  logic   set_evt;
  logic   clr_evt;
  logic   arm;

  assign mode = sense_e'(mode_i);

  always_comb begin
    case (mode)
      SENSE_LOW:  set_evt = !lvl;
      SENSE_FALL: set_evt = lvl_d && !lvl;
      SENSE_RISE: set_evt = !lvl_d && lvl;
      default:    set_evt = lvl_d ^ lvl;
    endcase
  end

  assign clr_evt = (wr && !wbit && arm)
                 || (svc && ((mode != SENSE_LOW) || lvl))
                 || (xfer && !keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (hw_standby) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else begin
      if (set_evt)      flag <= 1'b1;
      else if (clr_evt) flag <= 1'b0;
      if (wr)                arm <= 1'b0;
      else if (rd && flag)   arm <= 1'b1;
    end
  end

  p_standby_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> !flag);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_standby && set_evt) |=> flag);

  p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_standby && flag && wr && wbit && !svc && !xfer) |=> flag);

  p_armed_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_standby && !set_evt && wr && !wbit && arm) |=> !flag);

  p_level_svc_low_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_standby && mode == SENSE_LOW && !lvl && svc) |=> flag);
endmodule

// File: rtl/irq_sense_status.sv
`timescale 1ns/1ps
module irq_sense_status #(
  parameter int NLINES = 6,
  parameter int REG_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_standby,
  input  logic [NLINES-1:0]   irq_pin,
  input  logic [2*NLINES-1:0] sense_sel,
  input  logic [NLINES-1:0]   irq_en,
  input  logic                st_rd,
  input  logic                st_wr,
  input  logic [REG_W-1:0]    st_wdata,
  output logic [REG_W-1:0]    st_rdata,
  input  logic [NLINES-1:0]   svc_ack,
  input  logic [NLINES-1:0]   xfer_ack,
  input  logic [NLINES-1:0]   xfer_keep,
  output logic [NLINES-1:0]   irq_req
);
  localparam int PAD_W = REG_W - NLINES;

  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] lvl_d;
  logic [NLINES-1:0] flags;

  irq_sync #(.WIDTH(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (irq_pin),
    .lvl   (lvl),
    .lvl_d (lvl_d)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    irq_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_standby (hw_standby),
      .lvl        (lvl[n]),
      .lvl_d      (lvl_d[n]),
      .mode_i     (sense_sel[2*n+1:2*n]),
      .rd         (st_rd),
      .wr         (st_wr),
      .wbit       (st_wdata[n]),
      .svc        (svc_ack[n]),
      .xfer       (xfer_ack[n]),
      .keep       (xfer_keep[n]),
      .flag       (flags[n])
    );
  end

  if (PAD_W > 0) begin : g_pad
    assign st_rdata = {{PAD_W{1'b0}}, flags};
  end else begin : g_nopad
    assign st_rdata = flags[REG_W-1:0];
  end

  assign irq_req = flags & irq_en;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_rdata[REG_W-1:NLINES] == '0);

  p_req_gated_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~irq_en) == '0);

  p_req_matches_status_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (st_rdata[NLINES-1:0] & irq_en));
endmodule

// File: tb/test_irq_sense_status.sv
`timescale 1ns/1ps
module test_irq_sense_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_standby = 1'b0;
  logic [5:0]  irq_pin = 6'h3F;
  logic [11:0] sense_sel = 12'h000;
  logic [5:0]  irq_en = 6'h3F;
  logic        st_rd = 1'b0;
  logic        st_wr = 1'b0;
  logic [7:0]  st_wdata = 8'h00;
  logic [7:0]  st_rdata;
  logic [5:0]  svc_ack = 6'h00;
  logic [5:0]  xfer_ack = 6'h00;
  logic [5:0]  xfer_keep = 6'h00;
  logic [5:0]  irq_req;

  int    n_tests = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    done = 0;
  string phase = "R1 idle";

  always #2 clk = ~clk;

  irq_sense_status i_irq_sense_status (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .irq_pin(irq_pin),
    .sense_sel(sense_sel), .irq_en(irq_en), .st_rd(st_rd), .st_wr(st_wr),
    .st_wdata(st_wdata), .st_rdata(st_rdata), .svc_ack(svc_ack),
    .xfer_ack(xfer_ack), .xfer_keep(xfer_keep), .irq_req(irq_req)
  );

  // Reference model: pin history and pending state, updated per edge.
  logic [5:0] seen[$];
  bit   [5:0] m_flag;
  bit   [5:0] m_arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   = '{6'h3F, 6'h3F, 6'h3F};
      m_flag = '0;
      m_arm  = '0;
    end else begin
      bit [5:0] now_l, old_l;
      now_l = seen[1];
      old_l = seen[2];
      if (hw_standby) begin
        m_flag = '0;
        m_arm  = '0;
      end else begin
        for (int k = 0; k < 6; k++) begin
          int  md;
          bit  s, c;
          md = sense_sel[2*k +: 2];
          case (md)
            0: s = !now_l[k];
            1: s = old_l[k] && !now_l[k];
            2: s = !old_l[k] && now_l[k];
            default: s = old_l[k] != now_l[k];
          endcase
          c = (st_wr && !st_wdata[k] && m_arm[k])
            || (svc_ack[k] && (md != 0 || now_l[k]))
            || (xfer_ack[k] && !xfer_keep[k]);
          if (st_wr) begin
            if (s) m_flag[k] = 1'b1;
            else if (c) m_flag[k] = 1'b0;
            m_arm[k] = 1'b0;
          end else begin
            if (st_rd && m_flag[k]) m_arm[k] = 1'b1;
            if (s) m_flag[k] = 1'b1;
            else if (c) m_flag[k] = 1'b0;
          end
        end
      end
      seen.push_front(irq_pin);
      void'(seen.pop_back());
    end
  end

  // Compare on every falling edge once out of reset.
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      n_tests++;
      if (st_rdata !== {2'b00, m_flag} || irq_req !== (m_flag & irq_en)) begin
        n_fail++;
        $display("FAIL %s (R1/R13 view) rdata=%h exp=%h req=%h exp=%h",
                 phase, st_rdata, {2'b00, m_flag}, irq_req, m_flag & irq_en);
      end
    end
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired in phase %s got running expected stopped", phase);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    st_rd = 1'b1; step(1); st_rd = 1'b0;
  endtask

  task automatic do_write(logic [7:0] d);
    st_wr = 1'b1; st_wdata = d; step(1); st_wr = 1'b0;
  endtask

  task automatic expect_flags(string tag, logic [5:0] e);
    n_tests++;
    if (st_rdata !== {2'b00, e}) begin
      n_fail++;
      $display("FAIL %s rdata=%h exp=%h", tag, st_rdata, {2'b00, e});
    end
  endtask

  initial begin
    step(3);
    n_tests++;
    if (st_rdata !== 8'h00 || irq_req !== 6'h00) begin
      n_fail++;
      $display("FAIL R2 reset state rdata=%h exp=00", st_rdata);
    end
    rst_n = 1'b1;
    step(4);

    phase = "R3 low level";
    irq_pin[0] = 1'b0; step(2);
    expect_flags("R3 before sync latency", 6'h00);
    step(1);
    expect_flags("R3 after three edges", 6'h01);
    irq_pin[0] = 1'b1; step(5);
    expect_flags("R3 flag held after release", 6'h01);

    phase = "R7 ignored writes";
    do_write(8'hFF); step(1);
    expect_flags("R7 write one", 6'h01);
    do_write(8'h00); step(1);
    expect_flags("R7 zero without read", 6'h01);

    phase = "R8 read then clear";
    do_read(); do_write(8'h00); step(1);
    expect_flags("R8 handshake clear", 6'h00);
    irq_pin[0] = 1'b0; step(5); irq_pin[0] = 1'b1; step(4);
    do_write(8'h00); step(1);
    expect_flags("R8 arm consumed", 6'h01);
    do_read(); do_write(8'hFE); step(1);
    expect_flags("R8 clear zero bit", 6'h00);

    phase = "R4 R5 R6 edges";
    sense_sel = 12'b00_00_11_10_01_00;
    irq_pin[1] = 1'b0; irq_pin[2] = 1'b0; irq_pin[3] = 1'b0; step(5);
    expect_flags("R4 fall sets, R5 no set, R6 set", 6'b001010);
    irq_pin[1] = 1'b1; irq_pin[2] = 1'b1; irq_pin[3] = 1'b1; step(5);
    expect_flags("R5 rise sets", 6'b001110);

    phase = "R10 service in edge mode";
    svc_ack = 6'b001110; step(1); svc_ack = '0; step(1);
    expect_flags("R10 cleared", 6'h00);

    phase = "R9 service in level mode";
    irq_pin[0] = 1'b0; step(5); irq_pin[0] = 1'b1; step(1);
    svc_ack[0] = 1'b1; step(1); svc_ack[0] = 1'b0; step(1);
    expect_flags("R9 pin still low in sync", 6'h01);
    step(3);
    svc_ack[0] = 1'b1; step(1); svc_ack[0] = 1'b0; step(1);
    expect_flags("R9 pin high clears", 6'h00);

    phase = "R11 transfer ack";
    irq_pin[1] = 1'b0; step(5); irq_pin[1] = 1'b1;
    xfer_keep[1] = 1'b1; xfer_ack[1] = 1'b1; step(1); xfer_ack[1] = 1'b0; step(1);
    expect_flags("R11 keep set", 6'h02);
    xfer_keep[1] = 1'b0; xfer_ack[1] = 1'b1; step(1); xfer_ack[1] = 1'b0; step(1);
    expect_flags("R11 keep clear", 6'h00);

    phase = "R12 set wins";
    irq_pin[0] = 1'b0; step(5);
    svc_ack[0] = 1'b1; xfer_ack[0] = 1'b1; step(1); svc_ack = '0; xfer_ack = '0;
    do_read(); do_write(8'h00); step(1);
    expect_flags("R12 held against clears", 6'h01);

    phase = "R2 standby";
    hw_standby = 1'b1; step(1);
    expect_flags("R2 standby clear", 6'h00);
    hw_standby = 1'b0; irq_pin[0] = 1'b1; step(5);

    phase = "R13 enable gating";
    irq_en = 6'b010101;
    irq_pin[4] = 1'b0; irq_pin[5] = 1'b0; step(6);
    irq_pin = 6'h3F; step(4);

    phase = "mixed R12 random";
    for (int t = 0; t < 3000; t++) begin
      irq_pin   = 6'($urandom);
      if (t % 97 == 0) sense_sel = 12'($urandom);
      irq_en    = 6'($urandom);
      svc_ack   = 6'($urandom) & 6'($urandom);
      xfer_ack  = 6'($urandom) & 6'($urandom);
      xfer_keep = 6'($urandom);
      st_rd     = ($urandom % 4) == 0;
      st_wr     = ($urandom % 5) == 0;
      st_wdata  = 8'($urandom);
      hw_standby = ($urandom % 200) == 0;
      step(1);
    end
    st_rd = 0; st_wr = 0; svc_ack = 0; xfer_ack = 0; hw_standby = 0;
    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule